// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block sits between a bank of asynchronous wakeup interrupt inputs and a downstream interrupt controller that accepts only two kinds of request: an active-high level or a rising-edge pulse. Each input line has its own 3-bit trigger-type setting and its own enable bit. The block turns each line into one of those two accepted forms. Active-low levels come out as active-high levels. Falling edges come out as single-cycle pulses. Dual-edge lines give one pulse for every transition in either direction.

Software sets up the lines through a small memory-mapped register port. Enable bits are packed 32 to a word, and software updates them with whole-word read-modify-write. Each line also has its own configuration word. When software rewrites a line's trigger type, the internal inverter can flip even though the pin has not moved. The block masks any edge request that such a rewrite would create, so the downstream controller never sees a false wakeup.

Top module: `wake_irq_normalizer`

## Requirements
- R1: After reset every enable bit reads 0, every configuration word reads 3'b100 (level active-high), and every `irq_out` bit is 0.
- R2: A line configured 3'b100 and enabled drives `irq_out` equal to its input, 3 clock edges after the input changes.
- R3: A line configured 3'b000 and enabled drives `irq_out` equal to the inverse of its input, with the same 3-edge latency.
- R4: A line configured 3'b110 and enabled gives a pulse exactly one cycle wide on `irq_out` for each low-to-high input transition, 3 edges after it, and nothing for high-to-low transitions.
- R5: A line configured 3'b010 and enabled gives a pulse exactly one cycle wide for each high-to-low input transition, and nothing for low-to-high transitions.
- R6: A line configured 3'b111 and enabled gives a pulse exactly one cycle wide for each input transition in either direction.
- R7: Enable word w is at byte address 0x10 + 4*w. Line n is controlled by word n/32, bit n%32. A write replaces the whole word, so a read-modify-write of one bit leaves the other bits as they were. Bits for lines at or above NUM_IRQ read 0.
- R8: The configuration of line n is at byte address 0x110 + 4*n. Bits [2:0] are stored and read back, upper bits read 0, and the stored configuration changes only on a bus write.
- R9: A disabled line holds `irq_out` at 0 from the cycle after its enable bit clears. Edges that occur while it is disabled are not replayed when it is enabled again.
- R10: A write that changes a line's configuration to a different edge-type value produces no pulse from that change alone, even when the new polarity inverts a steady input.
- R11: The unlisted encodings 3'b001, 3'b011 and 3'b101 are stored and read back, but the line keeps `irq_out` at 0 while it holds one of them.
- R12: `bus_rdata` carries the addressed register one cycle after `bus_rd`. Unmapped addresses read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_in | input | NUM_IRQ | Asynchronous wakeup inputs |
| irq_out | output | NUM_IRQ | Normalized active-high or rising-pulse requests |

## Verification
Directed sequences drive each trigger type with a rise and then a fall. This shows that rising-only, falling-only and both-edge detection differ, and that the level modes follow or invert the pin. The polarity-flip case rewrites a rising-edge line to falling-edge while its input is held low. That exposes a false pulse that a design without masking would emit. A disabled line is also toggled and then re-enabled, which separates correct gating from replay of stored edges. A long random phase then runs with mixed per-line types, mixed enables and sparse random toggling on all lines at once. It is compared every cycle against a reference computed from the requirements, which catches crosstalk between lines and latency errors.

// File: rtl/wk_pkg.sv
package wk_pkg;

  localparam int unsigned TRIG_W   = 3;
  localparam int unsigned EN_BASE  = 16;   // byte address of the first enable word
  localparam int unsigned CFG_BASE = 272;  // byte address of line 0 configuration

  localparam logic [TRIG_W-1:0] TRIG_LVL_LO = 3'b000;
  localparam logic [TRIG_W-1:0] TRIG_FALL   = 3'b010;
  localparam logic [TRIG_W-1:0] TRIG_LVL_HI = 3'b100;
  localparam logic [TRIG_W-1:0] TRIG_RISE   = 3'b110;
  localparam logic [TRIG_W-1:0] TRIG_BOTH   = 3'b111;

  typedef struct packed {
    logic valid;    // encoding is one of the supported ones
    logic inv;      // invert the pin before detection
    logic is_edge;  // edge (pulse) rather than level
    logic dual;     // pulse on both directions
  } trig_dec_t;

  function automatic trig_dec_t decode_trig(input logic [TRIG_W-1:0] c);
    trig_dec_t d;
    d = '0;
    case (c)
      TRIG_LVL_LO: begin d.valid = 1'b1; d.inv = 1'b1; end
      TRIG_FALL:   begin d.valid = 1'b1; d.inv = 1'b1; d.is_edge = 1'b1; end
      TRIG_LVL_HI: begin d.valid = 1'b1; end
      TRIG_RISE:   begin d.valid = 1'b1; d.is_edge = 1'b1; end
      TRIG_BOTH:   begin d.valid = 1'b1; d.is_edge = 1'b1; d.dual = 1'b1; end
      default:     d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign q_sync = stage2;

endmodule

// File: rtl/wk_regs.sv
module wk_regs
  import wk_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic [NUM_IRQ-1:0]        en_bits,
  output logic [NUM_IRQ*TRIG_W-1:0] cfg_flat,
  output logic [NUM_IRQ-1:0]        cfg_chg
);

  localparam int unsigned N_WORDS = (NUM_IRQ + 31) / 32;
  localparam logic [ADDR_W-1:0] EN_LO  = ADDR_W'(EN_BASE);
  localparam logic [ADDR_W-1:0] EN_HI  = ADDR_W'(EN_BASE + 4 * N_WORDS);
  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + 4 * NUM_IRQ);

  function automatic logic [31:0] word_mask(input int unsigned w);
    logic [31:0] m;
    for (int unsigned b = 0; b < 32; b++) m[b] = ((w * 32 + b) < NUM_IRQ);
    return m;
  endfunction

  logic              aligned;
  logic              en_hit;
  logic              cfg_hit;
  logic [ADDR_W-1:0] en_idx;
  logic [ADDR_W-1:0] cfg_idx;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign en_hit  = aligned && (bus_addr >= EN_LO)  && (bus_addr < EN_HI);
  assign cfg_hit = aligned && (bus_addr >= CFG_LO) && (bus_addr < CFG_HI);
  assign en_idx  = (bus_addr - EN_LO) >> 2;
  assign cfg_idx = (bus_addr - CFG_LO) >> 2;

  logic [31:0]       en_word [N_WORDS];
  logic [TRIG_W-1:0] cfg_q   [NUM_IRQ];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_enw
    always_ff @(posedge clk) begin
      if (rst) begin
        en_word[w] <= '0;
      end else if (bus_wr && en_hit && (en_idx == ADDR_W'(w))) begin
        en_word[w] <= bus_wdata & word_mask(w);
      end
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[i]   <= TRIG_LVL_HI;
        cfg_chg[i] <= 1'b0;
      end else begin
        cfg_chg[i] <= 1'b0;
        if (bus_wr && cfg_hit && (cfg_idx == ADDR_W'(i))) begin
          cfg_q[i]   <= bus_wdata[TRIG_W-1:0];
          cfg_chg[i] <= (bus_wdata[TRIG_W-1:0] != cfg_q[i]);
        end
      end
    end
    assign cfg_flat[i*TRIG_W +: TRIG_W] = cfg_q[i];
    assign en_bits[i] = en_word[i / 32][i % 32];
  end

  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int unsigned w = 0; w < N_WORDS; w++) begin
      if (en_hit && (en_idx == ADDR_W'(w))) rd_mux = en_word[w];
    end
    for (int unsigned i = 0; i < NUM_IRQ; i++) begin
      if (cfg_hit && (cfg_idx == ADDR_W'(i))) rd_mux = {{(32-TRIG_W){1'b0}}, cfg_q[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/wk_line.sv
module wk_line
  import wk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_sync,
  input  logic [TRIG_W-1:0] cfg,
  input  logic              cfg_chg,
  input  logic              en,
  output logic              irq
);

  trig_dec_t dec;
  logic      norm;
  logic      norm_prev;
  logic      irq_nxt;

  assign dec  = decode_trig(cfg);
  assign norm = pin_sync ^ dec.inv;

  always_comb begin
    if (!dec.valid || !en) begin
      irq_nxt = 1'b0;
    end else if (!dec.is_edge) begin
      irq_nxt = norm;
    end else if (cfg_chg) begin
      irq_nxt = 1'b0;  // a type change resets edge history without a request
    end else if (dec.dual) begin
      irq_nxt = norm ^ norm_prev;
    end else begin
      irq_nxt = norm & ~norm_prev;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      norm_prev <= 1'b0;
      irq       <= 1'b0;
    end else begin
      norm_prev <= norm;
      irq       <= irq_nxt;
    end
  end

endmodule

// File: rtl/wake_irq_normalizer.sv
module wake_irq_normalizer
  import wk_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [NUM_IRQ-1:0] irq_out
);

  logic [NUM_IRQ-1:0]        en_bits;
  logic [NUM_IRQ*TRIG_W-1:0] cfg_flat;
  logic [NUM_IRQ-1:0]        cfg_chg;
  logic [NUM_IRQ-1:0]        pin_sync;

  wk_regs #(
    .NUM_IRQ (NUM_IRQ),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .en_bits   (en_bits),
    .cfg_flat  (cfg_flat),
    .cfg_chg   (cfg_chg)
  );

  wk_sync #(
    .W (NUM_IRQ)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (irq_in),
    .q_sync  (pin_sync)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    wk_line u_line (
      .clk      (clk),
      .rst      (rst),
      .pin_sync (pin_sync[i]),
      .cfg      (cfg_flat[i*TRIG_W +: TRIG_W]),
      .cfg_chg  (cfg_chg[i]),
      .en       (en_bits[i]),
      .irq      (irq_out[i])
    );
  end

endmodule

// File: rtl/wake_irq_normalizer_chk.sv
module wake_irq_normalizer_chk #(
  parameter int unsigned NUM_IRQ = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr,
  input logic [NUM_IRQ-1:0]   irq_out,
  input logic [NUM_IRQ-1:0]   en_bits,
  input logic [NUM_IRQ*3-1:0] cfg_flat,
  input logic [NUM_IRQ-1:0]   cfg_chg
);

  assert_off_when_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    ((irq_out & ~$past(en_bits)) == '0));

  assert_cfg_only_on_write_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(cfg_flat));

  assert_en_only_on_write_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(en_bits));

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ln
    logic [2:0] c;
    logic       single_edge;
    logic       any_edge;
    logic       unlisted;
    assign c           = cfg_flat[i*3 +: 3];
    assign single_edge = (c == 3'b110) || (c == 3'b010);
    assign any_edge    = single_edge || (c == 3'b111);
    assign unlisted    = (c == 3'b001) || (c == 3'b011) || (c == 3'b101);

    assert_pulse_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
      (irq_out[i] && single_edge) |=> !irq_out[i]);

    assert_change_masked_R10: assert property (@(posedge clk) disable iff (rst)
      (cfg_chg[i] && any_edge) |=> !irq_out[i]);

    assert_unlisted_quiet_R11: assert property (@(posedge clk) disable iff (rst)
      unlisted |=> !irq_out[i]);
  end

endmodule

bind wake_irq_normalizer wake_irq_normalizer_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .irq_out  (irq_out),
  .en_bits  (en_bits),
  .cfg_flat (cfg_flat),
  .cfg_chg  (cfg_chg)
);

// File: tb/wake_irq_normalizer_bench.sv
`timescale 1ns/1ps
module wake_irq_normalizer_bench;

  localparam int NI = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NI-1:0] irq_in = '0;
  logic [NI-1:0] irq_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wake_irq_normalizer #(.NUM_IRQ(NI), .ADDR_W(12)) u_wake_irq_normalizer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 12'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int en_addr(input int w);  return 16 + 4 * w;  endfunction
  function automatic int cfg_addr(input int n); return 272 + 4 * n; endfunction

  task automatic set_en(input int n, input logic on);
    logic [31:0] v;
    bus_read(en_addr(n / 32), v);
    v[n % 32] = on;
    bus_write(en_addr(n / 32), v);
  endtask

  function automatic logic exp_bit(input logic [2:0] c, input logic e,
                                   input logic cur, input logic prv);
    case (c)
      3'b100:  return e & cur;
      3'b000:  return e & ~cur;
      3'b110:  return e & cur & ~prv;
      3'b010:  return e & ~cur & prv;
      3'b111:  return e & (cur ^ prv);
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0]   rv;
    logic [2:0]    cfg_m [NI];
    logic [NI-1:0] en_m;
    logic [NI-1:0] d1, d2, d3, d4, nx, expv;

    void'($urandom(32'd9137));
    tick(4);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    chk("R1 out", 64'(irq_out), 64'd0);
    bus_read(en_addr(0), rv);  chk("R1 en0", 64'(rv), 64'd0);
    bus_read(en_addr(1), rv);  chk("R1 en1", 64'(rv), 64'd0);
    bus_read(cfg_addr(0), rv); chk("R1 cfg0", 64'(rv), 64'd4);
    bus_read(cfg_addr(39), rv); chk("R1 cfg39", 64'(rv), 64'd4);

    // R7 enable bank layout and read-modify-write
    bus_write(en_addr(0), 32'hA5A5_0F0F);
    bus_read(en_addr(0), rv);  chk("R7 word0", 64'(rv), 64'hA5A5_0F0F);
    bus_write(en_addr(1), 32'hFFFF_FFFF);
    bus_read(en_addr(1), rv);  chk("R7 unused bits", 64'(rv), 64'h0000_00FF);
    set_en(3, 1'b0);
    bus_read(en_addr(0), rv);  chk("R7 rmw clear", 64'(rv), 64'hA5A5_0F07);
    set_en(36, 1'b0);
    bus_read(en_addr(1), rv);  chk("R7 rmw word1", 64'(rv), 64'h0000_00EF);
    bus_read(en_addr(0), rv);  chk("R7 other word", 64'(rv), 64'hA5A5_0F07);

    // R12 unmapped space
    bus_write(8, 32'hFFFF_FFFF);
    bus_write(24, 32'hFFFF_FFFF);
    bus_read(8, rv);           chk("R12 unmapped", 64'(rv), 64'd0);
    bus_read(en_addr(0), rv);  chk("R12 no side effect", 64'(rv), 64'hA5A5_0F07);
    bus_read(cfg_addr(40), rv); chk("R12 past cfg", 64'(rv), 64'd0);

    // R8 configuration field
    bus_write(cfg_addr(5), 32'hFFFF_FFF6);
    bus_read(cfg_addr(5), rv); chk("R8 cfg readback", 64'(rv), 64'd6);

    bus_write(en_addr(0), 32'hFFFF_FFFF);
    bus_write(en_addr(1), 32'h0000_00FF);

    // R2 level high
    irq_in[2] = 1'b1;
    tick(2); chk("R2 latency", 64'(irq_out[2]), 64'd0);
    tick(1); chk("R2 high", 64'(irq_out[2]), 64'd1);
    irq_in[2] = 1'b0;
    tick(3); chk("R2 low", 64'(irq_out[2]), 64'd0);

    // R3 level low
    bus_write(cfg_addr(3), 32'h0);
    tick(1); chk("R3 inverted low", 64'(irq_out[3]), 64'd1);
    irq_in[3] = 1'b1;
    tick(3); chk("R3 inverted high", 64'(irq_out[3]), 64'd0);
    irq_in[3] = 1'b0;

    // R4 rising edge
    bus_write(cfg_addr(4), 32'h6);
    tick(2);
    irq_in[4] = 1'b1;
    tick(3); chk("R4 pulse", 64'(irq_out[4]), 64'd1);
    tick(1); chk("R4 one cycle", 64'(irq_out[4]), 64'd0);
    irq_in[4] = 1'b0;
    tick(3); chk("R4 no fall pulse", 64'(irq_out[4]), 64'd0);
    tick(1); chk("R4 no fall pulse b", 64'(irq_out[4]), 64'd0);

    // R5 falling edge (cfg written 0x2 from 0x6)
    bus_write(cfg_addr(5), 32'h2);
    tick(3); chk("R10 no phantom line5", 64'(irq_out[5]), 64'd0);
    irq_in[5] = 1'b1;
    tick(3); chk("R5 no rise pulse", 64'(irq_out[5]), 64'd0);
    irq_in[5] = 1'b0;
    tick(3); chk("R5 pulse", 64'(irq_out[5]), 64'd1);
    tick(1); chk("R5 one cycle", 64'(irq_out[5]), 64'd0);

    // R6 dual edge
    bus_write(cfg_addr(6), 32'h7);
    tick(2);
    irq_in[6] = 1'b1;
    tick(3); chk("R6 rise pulse", 64'(irq_out[6]), 64'd1);
    tick(1); chk("R6 one cycle", 64'(irq_out[6]), 64'd0);
    irq_in[6] = 1'b0;
    tick(3); chk("R6 fall pulse", 64'(irq_out[6]), 64'd1);
    tick(1); chk("R6 one cycle b", 64'(irq_out[6]), 64'd0);

    // R10 polarity flip with steady low input
    bus_write(cfg_addr(7), 32'h6);
    tick(3);
    bus_write(cfg_addr(7), 32'h2);
    chk("R10 flip t0", 64'(irq_out[7]), 64'd0);
    tick(1); chk("R10 flip t1", 64'(irq_out[7]), 64'd0);
    tick(1); chk("R10 flip t2", 64'(irq_out[7]), 64'd0);
    tick(1); chk("R10 flip t3", 64'(irq_out[7]), 64'd0);

    // R9 disabled line
    bus_write(cfg_addr(8), 32'h6);
    set_en(8, 1'b0);
    irq_in[8] = 1'b1;
    tick(3); chk("R9 disabled edge", 64'(irq_out[8]), 64'd0);
    set_en(8, 1'b1);
    chk("R9 no replay a", 64'(irq_out[8]), 64'd0);
    tick(1); chk("R9 no replay b", 64'(irq_out[8]), 64'd0);
    irq_in[2] = 1'b1;
    set_en(2, 1'b0);
    tick(3); chk("R9 level gated", 64'(irq_out[2]), 64'd0);
    set_en(2, 1'b1);
    tick(1); chk("R9 level returns", 64'(irq_out[2]), 64'd1);

    // R11 unlisted encoding
    bus_write(cfg_addr(9), 32'h5);
    bus_read(cfg_addr(9), rv); chk("R11 stored", 64'(rv), 64'd5);
    irq_in[9] = 1'b1;
    tick(3); chk("R11 quiet high", 64'(irq_out[9]), 64'd0);
    irq_in[9] = 1'b0;
    tick(3); chk("R11 quiet low", 64'(irq_out[9]), 64'd0);

    // Random phase: R2 R3 R4 R5 R6 R9 R11 across all lines
    for (int n = 0; n < NI; n++) begin
      case ($urandom_range(0, 6))
        0: cfg_m[n] = 3'b000;
        1: cfg_m[n] = 3'b010;
        2: cfg_m[n] = 3'b100;
        3: cfg_m[n] = 3'b110;
        4: cfg_m[n] = 3'b111;
        5: cfg_m[n] = 3'b011;
        default: cfg_m[n] = 3'b111;
      endcase
      bus_write(cfg_addr(n), {29'd0, cfg_m[n]});
    end
    en_m = NI'({$urandom | $urandom, $urandom | $urandom});
    bus_write(en_addr(0), en_m[31:0]);
    bus_write(en_addr(1), {24'd0, en_m[39:32]});
    tick(6);
    d1 = irq_in; d2 = irq_in; d3 = irq_in; d4 = irq_in;
    for (int c = 0; c < 600; c++) begin
      for (int n = 0; n < NI; n++) expv[n] = exp_bit(cfg_m[n], en_m[n], d3[n], d4[n]);
      chk("R2-R6 random (R4 R5 R6)", 64'(irq_out), 64'(expv));
      nx = irq_in ^ (NI'({$urandom, $urandom}) & NI'({$urandom, $urandom}));
      irq_in = nx;
      d4 = d3; d3 = d2; d2 = d1; d1 = nx;
      tick(1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule